// File: doc/BRIEF.md
# Sticky-Status Interrupt Controller

This block gathers a small set of interrupt request pins, eight by default, into one interrupt line for a processor. A parameter sets the trigger mode of each pin. A pin in level mode is latched while it is high. A pin in edge mode is latched on a low-to-high transition. Each pin has a status bit. Once set, the bit stays set until software clears it. Dropping the pin does not clear it.

Software works through four word registers on a simple write-strobe bus with a combinational read port. The registers are a status register, an enable mask, a write-only acknowledge register and a two-bit master control register. Bit 0 of the master control register gates the output. Bit 1 switches the controller into hardware-interrupt mode. Once set, that bit stays set until reset, and while it is set the status register cannot be written directly.

Top module: `irq_ctrl`

## Requirements
- R1: Parameter `EDGE_MASK` selects the trigger mode of each pin: bit i = 1 makes pin i edge-triggered, bit i = 0 makes it level-sensitive. The default sets the upper half of the pins (bits 4..7 when N = 8) to edge mode.
- R2: A level-sensitive pin sampled high at a rising clock edge sets its status bit, and the bit is visible right after that edge.
- R3: A status bit does not clear when its pin goes low. It clears only through a software write (R5, R6).
- R4: An edge-triggered pin sets its status bit only at an edge where it is sampled 1 and was sampled 0 at the previous edge. A pin held high after an acknowledge does not set the bit again.
- R5: A write to the status register (address 0) replaces its contents only while control bit 1 is 0. While control bit 1 is 1 the write is ignored.
- R6: Writing the acknowledge register (address 2) clears every status bit whose write-data bit is 1 and leaves the others unchanged. This register holds no state and reads as 0.
- R7: `irq_out` is 1 exactly when control bit 0 is 1 and status AND enable is non-zero. It follows the registers with no extra delay.
- R8: When a set event and a software clear reach the same status bit at the same edge, the bit ends up set.
- R9: Control bit 1 (address 3, bit 1) can be set by software but not cleared. Bit 0 is freely writable.
- R10: Reset clears status, enable and control, so every register reads 0 and `irq_out` is 0.
- R11: The register map is: 0 status, 1 enable (read/write), 2 acknowledge, 3 control (bits 1:0, upper bits read 0). `rdata` reflects `addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N | Interrupt request pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | N | Write data |
| rdata | output | N | Read data for `addr` |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
Pin samples and register writes take effect at the next rising edge. Status and enable are registered and `irq_out` is decoded from them combinationally. So every input applied before an edge shows on `rdata` and `irq_out` immediately after that edge, one cycle of latency in all. The bench drives each input set at a falling edge and checks the outputs against a reference model of the current state. It then advances the model, and the next edge follows. This way every sample is taken half a cycle away from the active edge.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N = 8,
  parameter logic [N-1:0] EDGE_MASK = {N{1'b1}} << (N/2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  output logic         irq_out
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_ACK  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [N-1:0] stat, mask, prev, set_vec, stat_nxt;
  logic [1:0]   ctrl;

  wire stat_wr = wr_en && addr == A_STAT && !ctrl[1];
  wire ack_wr  = wr_en && addr == A_ACK;

  assign set_vec = (irq_in & ~EDGE_MASK) | (irq_in & ~prev & EDGE_MASK);

  always_comb begin
    stat_nxt = stat;
    if (stat_wr)     stat_nxt = wdata;
    else if (ack_wr) stat_nxt = stat & ~wdata;
    stat_nxt = stat_nxt | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
      ctrl <= '0;
      prev <= '0;
    end else begin
      stat <= stat_nxt;
      prev <= irq_in;
      if (wr_en && addr == A_MASK) mask <= wdata;
      if (wr_en && addr == A_CTRL) ctrl <= {ctrl[1] | wdata[1], wdata[0]};
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: rdata = stat;
      A_MASK: rdata = mask;
      A_CTRL: rdata[1:0] = ctrl;
      default: rdata = '0;
    endcase
  end

  assign irq_out = ctrl[0] && |(stat & mask);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_wr || ack_wr) |=> ((stat & $past(stat)) == $past(stat)));

  a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && ctrl[1]) |=> ((stat & $past(stat)) == $past(stat)));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~stat) == '0));

  a_r9_he_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] |=> ctrl[1]);

  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !irq_out);
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  localparam int N = 8;
  localparam logic [N-1:0] EM = 8'hF0;
  localparam real HALF = 2.5;

  logic clk = 0, rst_n = 0, wr_en = 0, irq_out;
  logic [N-1:0] irq_in = '0, wdata = '0, rdata;
  logic [1:0] addr = '0;
  int total = 0, bad = 0;
  logic done = 0;

  logic [N-1:0] m_stat, m_mask, m_prev;
  logic [1:0] m_ctrl;

  always #(HALF) clk = ~clk;

  irq_ctrl #(.N(N), .EDGE_MASK(EM)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

  function automatic logic [N-1:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_mask;
      2'd3: return {{(N-2){1'b0}}, m_ctrl};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] irq, input logic w, input logic [1:0] a,
                      input logic [N-1:0] d, input string tag);
    logic [N-1:0] s, base;
    irq_in = irq; wr_en = w; addr = a; wdata = d;
    #1;
    chk(tag, rdata, exp_rd(a));
    chk("R7", {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, m_ctrl[0] && |(m_stat & m_mask)});
    s = (irq & ~EM) | (irq & ~m_prev & EM);
    base = m_stat;
    if (w && a == 2'd0 && !m_ctrl[1]) base = d;
    else if (w && a == 2'd2) base = m_stat & ~d;
    m_stat = base | s;
    if (w && a == 2'd1) m_mask = d;
    if (w && a == 2'd3) m_ctrl = {m_ctrl[1] | d[1], d[0]};
    m_prev = irq;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_stat = '0; m_mask = '0; m_prev = '0; m_ctrl = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) step('0, 0, a[1:0], '0, "R10");
    // level pin 0: set, drop, stays
    step(8'h01, 0, 2'd0, '0, "R2");
    step(8'h00, 0, 2'd0, '0, "R2");
    step(8'h00, 0, 2'd0, '0, "R3");
    step(8'h00, 1, 2'd1, 8'h13, "R11");
    step(8'h00, 1, 2'd3, 8'h01, "R7");
    step(8'h00, 0, 2'd3, '0, "R11");
    // ack clears, reads zero
    step(8'h00, 1, 2'd2, 8'h01, "R6");
    step(8'h00, 0, 2'd0, '0, "R6");
    step(8'h00, 0, 2'd2, '0, "R6");
    // set beats ack
    step(8'h01, 1, 2'd2, 8'h01, "R8");
    step(8'h00, 0, 2'd0, '0, "R8");
    // edge pin 4 held high, ack, no re-set; level pin 1 held high re-sets
    step(8'h12, 0, 2'd0, '0, "R4");
    step(8'h12, 0, 2'd0, '0, "R4");
    step(8'h12, 1, 2'd2, 8'h13, "R1");
    step(8'h12, 0, 2'd0, '0, "R1");
    step(8'h12, 0, 2'd0, '0, "R4");
    step(8'h00, 0, 2'd0, '0, "R4");
    step(8'h10, 0, 2'd0, '0, "R4");
    step(8'h00, 0, 2'd0, '0, "R4");
    // direct status write, then lock
    step(8'h00, 1, 2'd0, 8'h0C, "R5");
    step(8'h00, 0, 2'd0, '0, "R5");
    step(8'h00, 1, 2'd3, 8'h03, "R9");
    step(8'h00, 1, 2'd0, 8'h00, "R5");
    step(8'h00, 0, 2'd0, '0, "R5");
    step(8'h00, 1, 2'd3, 8'h00, "R9");
    step(8'h00, 0, 2'd3, '0, "R9");
    step(8'h00, 0, 2'd0, '0, "R7");
    step(8'h00, 1, 2'd2, 8'hFF, "R6");
    // random traffic, with a reset to unlock first
    rst_n = 0; #1;
    m_stat = '0; m_mask = '0; m_prev = '0; m_ctrl = '0;
    chk("R10", {{(N-1){1'b0}}, irq_out}, '0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] pins;
      logic [1:0] a;
      logic w;
      pins = $urandom() & $urandom();
      a = 2'($urandom());
      w = ($urandom() % 3) == 0;
      if (a == 2'd3 && ($urandom() % 8) != 0) w = 0;
      step(pins, w, a, N'($urandom()), "R11");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule